// File: doc/BRIEF.md
# Sized Access Byte-Lane Generator

This block sits between a processor's load/store path and a 32-bit bus. It takes one request at a time. Each request carries a byte address, an access size and write data. The block turns each request into at most one bus cycle. The two low address bits never reach the bus: they become a four-bit byte-enable mask, and the upper bits form the word address.

On a store, the data is copied across the byte lanes so that the enabled lane always carries it. On a load, all four lanes are enabled. The lane that holds the wanted data is then shifted down to bit 0 and zero-extended before the result goes back to the requester.

A request whose address does not suit its size is rejected. It is never split into several cycles and no bus cycle is issued for it. Instead, the block acknowledges it with a one-cycle error response.

Top module: `lane_access_gen`

## Requirements
- R1: An accepted aligned request starts one bus cycle in the cycle after acceptance, with `bus_addr` equal to request address bits [ADDR_W-1:2].
- R2: Store byte enables are little-endian. For size 0 (byte) the mask is `1 << addr[1:0]`. For size 1 (halfword) it is 4'b0011 at offset 0 and 4'b1100 at offset 2. For size 2 (word) it is 4'b1111.
- R3: Every load drives `bus_be` = 4'b1111, whatever its size or offset.
- R4: Store data is replicated across the lanes. A byte appears on all four lanes, a halfword on both halves, and a word passes unchanged.
- R5: A halfword needs `addr[0]`=0 and a word needs `addr[1:0]`=0. A byte may use any offset. Size code 3 is always rejected.
- R6: A rejected request is accepted with `req_ready` high. In the next cycle it produces `rsp_valid` and `rsp_err` together for exactly one cycle, and `bus_valid` stays low.
- R7: While `bus_valid` is high and `bus_ready` is low, all bus outputs hold their values.
- R8: A load result is `bus_rdata` shifted right by 8 × `addr[1:0]`, then zero-extended from 8 bits (size 0) or 16 bits (size 1). A word load is returned unchanged.
- R9: `req_ready` is low while a bus cycle is outstanding. The cycle ends at the edge where `bus_ready` is high, and `rsp_valid` is high without `rsp_err` for the following cycle only. A store returns `rsp_rdata` = 0.
- R10: After reset, `bus_valid`, `rsp_valid` and `rsp_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| bus_valid | output | 1 | Bus cycle active |
| bus_ready | input | 1 | Bus completes the cycle |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | ADDR_W-2 | Word address |
| bus_be | output | 4 | Byte enables, bit n = lane [8n+7:8n] |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Load data, sampled with bus_ready |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a rejected request |
| rsp_rdata | output | 32 | Aligned, zero-extended load result |

## Verification
Several rules are checked by assertions on every cycle: the held bus outputs during a stall, the full mask on every load, the single-bit or two-bit store mask, the word address taken at acceptance, and the error response with no bus cycle for every misaligned request. The bench covers what those checks cannot see, which is the values themselves. It compares the exact lane chosen for each offset, the replicated store data, and the shifted and zero-extended load result against values it computes itself, under random sizes, offsets and bus stall lengths.

// File: rtl/lane_access_gen.sv
module lane_access_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-3:0] bus_addr,
  output logic [3:0]        bus_be,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic [1:0]  lo;
  logic        misal, accept;
  logic [3:0]  st_be;
  logic [31:0] rep_data, shifted, aligned_rd;
  logic [1:0]  off_q, size_q;

  assign lo     = req_addr[1:0];
  assign misal  = (req_size == 2'd3) ||
                  (req_size == SZ_HALF && lo[0]) ||
                  (req_size == SZ_WORD && lo != 2'b00);
  assign req_ready = !bus_valid;
  assign accept    = req_valid && req_ready;

  always_comb begin
    case (req_size)
      SZ_BYTE: st_be = 4'b0001 << lo;
      SZ_HALF: st_be = lo[1] ? 4'b1100 : 4'b0011;
      default: st_be = 4'b1111;
    endcase
  end

  always_comb begin
    case (req_size)
      SZ_BYTE: rep_data = {4{req_wdata[7:0]}};
      SZ_HALF: rep_data = {2{req_wdata[15:0]}};
      default: rep_data = req_wdata;
    endcase
  end

  assign shifted = bus_rdata >> {off_q, 3'b000};

  always_comb begin
    case (size_q)
      SZ_BYTE: aligned_rd = {24'd0, shifted[7:0]};
      SZ_HALF: aligned_rd = {16'd0, shifted[15:0]};
      default: aligned_rd = shifted;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      off_q     <= '0;
      size_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (bus_valid && bus_ready) begin
        bus_valid <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= bus_write ? 32'd0 : aligned_rd;
      end else if (accept) begin
        if (misal) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_rdata <= 32'd0;
        end else begin
          bus_valid <= 1'b1;
          bus_write <= req_write;
          bus_addr  <= req_addr[ADDR_W-1:2];
          bus_be    <= req_write ? st_be : 4'b1111;
          bus_wdata <= rep_data;
          off_q     <= lo;
          size_q    <= req_size;
        end
      end
    end
  end
endmodule

// File: rtl/lane_access_gen_chk.sv
module lane_access_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-3:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata
);
  logic bad;
  assign bad = (req_size == 2'd0) ? 1'b0 :
               (req_size == 2'd1) ? req_addr[0] :
               (req_size == 2'd2) ? (req_addr[1:0] != 2'b00) : 1'b1;

  // R1
  aligned_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bad) |=> (bus_valid && bus_addr == $past(req_addr[ADDR_W-1:2])));

  // R2
  store_mask_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |-> ($countones(bus_be) == 1 || bus_be == 4'b0011 ||
                                  bus_be == 4'b1100 || bus_be == 4'b1111));

  // R3
  load_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> bus_be == 4'b1111);

  // R6
  misaligned_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad) |=> (rsp_valid && rsp_err && !bus_valid));

  // R6
  err_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be) &&
                                   $stable(bus_wdata) && $stable(bus_write)));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  // R9
  complete_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> (rsp_valid && !rsp_err && !bus_valid));
endmodule

bind lane_access_gen lane_access_gen_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/lane_access_gen_test.sv
module lane_access_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, bus_ready = 0;
  logic [1:0] req_size = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0, bus_rdata = 0;
  logic req_ready, bus_valid, bus_write, rsp_valid, rsp_err;
  logic [ADDR_W-3:0] bus_addr;
  logic [3:0] bus_be;
  logic [31:0] bus_wdata, rsp_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  lane_access_gen #(.ADDR_W(ADDR_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(logic [1:0] sz, logic [1:0] lo);
    if (sz == 2'd3) return 1;
    if (sz == 2'd1) return lo[0];
    if (sz == 2'd2) return lo != 0;
    return 0;
  endfunction

  function automatic logic [3:0] exp_be(bit wr, logic [1:0] sz, logic [1:0] lo);
    if (!wr) return 4'hF;
    case (sz)
      2'd0: return 4'(1 << lo);
      2'd1: return (lo == 2) ? 4'b1100 : 4'b0011;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'd0: return {d[7:0], d[7:0], d[7:0], d[7:0]};
      2'd1: return {d[15:0], d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] sz, logic [1:0] lo, logic [31:0] r);
    logic [31:0] s;
    s = r >> (8 * lo);
    case (sz)
      2'd0: return s & 32'hFF;
      2'd1: return s & 32'hFFFF;
      default: return s;
    endcase
  endfunction

  task automatic access(bit wr, logic [1:0] sz, logic [31:0] addr, logic [31:0] wd,
                        logic [31:0] rd, int stall);
    @(negedge clk);
    check(req_ready == 1, "R9 ready when idle", 32'(req_ready), 1);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (is_bad(sz, addr[1:0])) begin
      // R5 R6
      check(rsp_valid && rsp_err && !bus_valid, "R6 reject pulse",
            {29'd0, rsp_valid, rsp_err, bus_valid}, 32'b110);
      @(negedge clk);
      check(!rsp_valid && !rsp_err && !bus_valid, "R6 single cycle no bus",
            {29'd0, rsp_valid, rsp_err, bus_valid}, 0);
      return;
    end
    check(bus_valid && bus_write == wr, "R1 bus cycle starts", {30'd0, bus_valid, bus_write}, {30'd0, 1'b1, wr});
    check(bus_addr == addr[31:2], "R1 word address", 32'(bus_addr), 32'(addr[31:2]));
    if (wr) begin
      check(bus_be == exp_be(1, sz, addr[1:0]), "R2 store mask", 32'(bus_be), 32'(exp_be(1, sz, addr[1:0])));
      check(bus_wdata == exp_wd(sz, wd), "R4 replicated data", bus_wdata, exp_wd(sz, wd));
    end else
      check(bus_be == 4'hF, "R3 load mask", 32'(bus_be), 32'hF);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(bus_valid && !req_ready && !rsp_valid, "R7 R9 stalled cycle",
            {29'd0, bus_valid, req_ready, rsp_valid}, 32'b100);
    end
    bus_ready = 1; bus_rdata = rd;
    @(negedge clk);
    bus_ready = 0; bus_rdata = $urandom;
    check(rsp_valid && !rsp_err && !bus_valid, "R9 completion", {29'd0, rsp_valid, rsp_err, bus_valid}, 32'b100);
    if (wr) check(rsp_rdata == 0, "R9 store result zero", rsp_rdata, 0);
    else check(rsp_rdata == exp_rd(sz, addr[1:0], rd), "R8 load result", rsp_rdata, exp_rd(sz, addr[1:0], rd));
    @(negedge clk);
    check(!rsp_valid, "R9 response one cycle", 32'(rsp_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    check(!bus_valid && !rsp_valid && !rsp_err && req_ready, "R10 reset state",
          {28'd0, bus_valid, rsp_valid, rsp_err, req_ready}, 1);
    for (int o = 0; o < 4; o++) access(1, 2'd0, 32'h1000 + o, 32'hA5C3_7E19, 0, 0);
    access(1, 2'd1, 32'h2002, 32'h0000_BEEF, 0, 1);
    access(1, 2'd1, 32'h2000, 32'h1234_CAFE, 0, 0);
    access(1, 2'd2, 32'h2004, 32'hDEAD_BEEF, 0, 2);
    access(0, 2'd0, 32'h3003, 0, 32'h8899_AABB, 0);
    access(0, 2'd1, 32'h3002, 0, 32'hF00D_1234, 1);
    access(0, 2'd2, 32'h3000, 0, 32'hCAFE_F00D, 0);
    access(1, 2'd1, 32'h4001, 32'h55, 0, 0);   // R5 odd halfword
    access(0, 2'd2, 32'h4002, 0, 0, 0);        // R5 word at offset 2
    access(1, 2'd3, 32'h4000, 32'h1, 0, 0);    // R5 size code 3
    for (int n = 0; n < 300; n++)
      access($urandom_range(0, 1), 2'($urandom_range(0, 3)), $urandom, $urandom,
             $urandom, $urandom_range(0, 3));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule